// File: doc/BRIEF.md
# Block Storage Controller Register Front-End

This block is the slave-side register front-end of a block-storage DMA controller. Software programs a memory buffer address, a block count and a starting block index over a simple word-addressed bus. It then writes an operation code that launches a transfer on a separate data-movement engine. The engine's final outcome is held in a status register that doubles as the control state. The block also drives a level-sensitive interrupt.

The status value is the control state itself. While a transfer is running, configuration writes are silently dropped. When the engine reports completion, the state moves to one of four terminal outcomes and the interrupt rises if it is enabled. A bus read of the status register in a terminal state returns the outcome, moves the state back to idle and clears the interrupt in a single access. The device capacity and the block size are fixed by parameters and can be read back.

Top module: `blkdev_ctrl_regs`

## Requirements
- R1: After reset the state is idle (status 0), the interrupt enable reads 1, buffer address, count and block index read 0, `irq` and `eng_start` are low, and no response is pending.
- R2: Word offsets are 0x00 buffer address bits 31:0, 0x04 block count, 0x08 first block index, 0x0C operation, 0x10 status, 0x14 interrupt enable, 0x18 device size in blocks, 0x1C block size in bytes, and 0x20 buffer address bits 63:32. Writable registers read back what was written. Offset 0x18 reads the `DEV_BLOCKS` parameter and offset 0x1C reads the `BLOCK_BYTES` parameter.
- R3: Each of the following returns `rsp_err`=1 with `rsp_rdata`=0 and changes no register or state: an offset with bits 1:0 non-zero, an offset above 0x20, a write to 0x10, 0x18 or 0x1C, and a read of 0x0C.
- R4: Every accepted request produces exactly one response, with `rsp_valid` high in the cycle after the request. Write responses carry `rsp_rdata`=0.
- R5: In idle, writing 1 (read: storage to memory) or 2 (write: memory to storage) to the operation register raises `eng_start` for exactly one cycle, in the cycle after the request. In that same cycle status reads 1 (busy), `eng_read` is 1 for code 1 and 0 for code 2, and `eng_buf_addr`, `eng_count` and `eng_lba` carry the programmed values.
- R6: Writing any other value to the operation register (0, or 3 and above) starts nothing, leaves the state idle and returns a normal response.
- R7: While the state is not idle, writes to buffer address (both halves), count, block index and operation are acknowledged without error but have no effect.
- R8: When `eng_done` is high in the busy state, the status becomes 2 (read ok), 3 (write ok), 4 (read failed) or 5 (write failed), chosen by the latched direction and by `eng_fail`. `eng_done` in any other state is ignored.
- R9: A status read returns the current code. If the code is 2 to 5, the state becomes idle at the same edge. In idle or busy the read changes nothing.
- R10: `irq` is high exactly when the status is 2 to 5 and the interrupt enable register is non-zero. The enable register is writable in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one request per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 on writes and on errors) |
| rsp_err | output | 1 | Error response |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_read | output | 1 | Transfer direction, 1 = storage to memory |
| eng_buf_addr | output | 64 | Memory buffer address |
| eng_count | output | 32 | Number of blocks |
| eng_lba | output | 32 | First block index |
| eng_done | input | 1 | Engine completion strobe |
| eng_fail | input | 1 | Completion outcome, 1 = failed, qualified by eng_done |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the engine raises `eng_done` only as a single-cycle strobe and only after a launch. They also assume that `bus_valid` is never X while out of reset. The bench drives completion only while a transfer is running, except for one deliberate stray strobe in idle that tests the ignore rule. It drives every bus request for exactly one cycle, followed by an idle cycle. Under these conditions the claims are checked: configuration does not move while the state is not idle, each launch is a lone pulse that coincides with busy, and a terminal state is only entered from busy on a completion strobe.

// File: rtl/blkdev_pkg.sv
// Package: shared state, register-select and operation encodings for the
// block storage register front-end. Assumes 32-bit registers on word offsets.
package blkdev_pkg;

    localparam int unsigned NUM_REGS = 9;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BUSY   = 3'd1,
        ST_RD_OK  = 3'd2,
        ST_WR_OK  = 3'd3,
        ST_RD_ERR = 3'd4,
        ST_WR_ERR = 3'd5
    } bd_state_e;

    typedef enum logic [3:0] {
        SEL_BUF_LO    = 4'd0,
        SEL_COUNT     = 4'd1,
        SEL_LBA       = 4'd2,
        SEL_OP        = 4'd3,
        SEL_STATUS    = 4'd4,
        SEL_IRQ_EN    = 4'd5,
        SEL_SIZE      = 4'd6,
        SEL_BLK_BYTES = 4'd7,
        SEL_BUF_HI    = 4'd8,
        SEL_NONE      = 4'd15
    } bd_sel_e;

    localparam logic [31:0] OPC_READ  = 32'd1;
    localparam logic [31:0] OPC_WRITE = 32'd2;

    // Terminal outcome test used by interrupt gating and acknowledge logic
    function automatic logic is_terminal(input bd_state_e st);
        return (st == ST_RD_OK) || (st == ST_WR_OK) ||
               (st == ST_RD_ERR) || (st == ST_WR_ERR);
    endfunction

endpackage

// File: rtl/blkdev_decode.sv
// Module: blkdev_decode
// Maps a byte offset to a register select and flags illegal accesses
// (misaligned, unmapped, write to read-only, read of write-only).
// Assumes ADDR_W >= 6 so that every mapped offset is reachable.
module blkdev_decode
    import blkdev_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output bd_sel_e           sel,
    output logic              err
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             misaligned;

    assign word_idx   = addr[ADDR_W-1:2];
    assign misaligned = |addr[1:0];

    // Word index to register select; anything past the map is unmapped
    always_comb begin
        sel = SEL_NONE;
        if (!misaligned) begin
            case (word_idx)
                IDX_W'(0): sel = SEL_BUF_LO;
                IDX_W'(1): sel = SEL_COUNT;
                IDX_W'(2): sel = SEL_LBA;
                IDX_W'(3): sel = SEL_OP;
                IDX_W'(4): sel = SEL_STATUS;
                IDX_W'(5): sel = SEL_IRQ_EN;
                IDX_W'(6): sel = SEL_SIZE;
                IDX_W'(7): sel = SEL_BLK_BYTES;
                IDX_W'(8): sel = SEL_BUF_HI;
                default:   sel = SEL_NONE;
            endcase
        end
    end

    // Access legality by direction
    always_comb begin
        err = (sel == SEL_NONE);
        if (write && (sel == SEL_STATUS || sel == SEL_SIZE || sel == SEL_BLK_BYTES))
            err = 1'b1;
        if (!write && sel == SEL_OP)
            err = 1'b1;
    end

    // R3
    decode_legal_chk: assert final ((sel != SEL_NONE) || err);

endmodule

// File: rtl/blkdev_cfg_regs.sv
// Module: blkdev_cfg_regs
// Holds the transfer configuration (buffer address, count, first block) and
// the interrupt enable. Configuration is only written in idle; the enable
// is writable at any time. Assumes wr_en is already qualified as legal.
module blkdev_cfg_regs
    import blkdev_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  bd_sel_e             sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                idle,
    output logic [2*DATA_W-1:0] buf_addr,
    output logic [DATA_W-1:0]   count,
    output logic [DATA_W-1:0]   lba,
    output logic [DATA_W-1:0]   irq_en
);
    logic cfg_we;
    assign cfg_we = wr_en && idle;

    // Protected configuration registers, written only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr <= '0;
            count    <= '0;
            lba      <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_BUF_LO: buf_addr[DATA_W-1:0]        <= wdata;
                SEL_BUF_HI: buf_addr[2*DATA_W-1:DATA_W] <= wdata;
                SEL_COUNT:  count                       <= wdata;
                SEL_LBA:    lba                         <= wdata;
                default: ;
            endcase
        end
    end

    // Interrupt enable, writable in every state, resets enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= DATA_W'(1);
        else if (wr_en && sel == SEL_IRQ_EN)
            irq_en <= wdata;
    end

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(buf_addr) && $stable(count) && $stable(lba));

endmodule

// File: rtl/blkdev_state_fsm.sv
// Module: blkdev_state_fsm
// Control state that is also the visible status code. Launches the engine,
// records its outcome and returns to idle on a status acknowledge.
// Assumes eng_done is a single-cycle strobe from the engine.
module blkdev_state_fsm
    import blkdev_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  logic      go_read,
    input  logic      ack_rd,
    input  logic      done,
    input  logic      fail,
    output bd_state_e state,
    output logic      start,
    output logic      dir_read
);
    // State, launch pulse and latched direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            start    <= 1'b0;
            dir_read <= 1'b0;
        end else begin
            start <= 1'b0;
            case (state)
                ST_IDLE: if (go) begin
                    state    <= ST_BUSY;
                    start    <= 1'b1;
                    dir_read <= go_read;
                end
                ST_BUSY: if (done) begin
                    if (dir_read) state <= fail ? ST_RD_ERR : ST_RD_OK;
                    else          state <= fail ? ST_WR_ERR : ST_WR_OK;
                end
                default: if (ack_rd) state <= ST_IDLE;
            endcase
        end
    end

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == ST_BUSY);

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_terminal(state) && ack_rd) |=> state == ST_IDLE);

    // R8
    outcome_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_terminal(state) && !is_terminal($past(state)))
            |-> ($past(state) == ST_BUSY && $past(done)));

endmodule

// File: rtl/blkdev_ctrl_regs.sv
// Module: blkdev_ctrl_regs (top)
// Register front-end of a block storage DMA controller: decodes bus
// accesses, returns registered responses, launches the transfer engine,
// exposes its outcome as status and gates the level interrupt.
// Assumes one request per cycle with no back-pressure.
module blkdev_ctrl_regs
    import blkdev_pkg::*;
#(
    parameter int          ADDR_W      = 6,
    parameter logic [31:0] DEV_BLOCKS  = 32'h0004_0000,
    parameter logic [31:0] BLOCK_BYTES = 32'd512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              eng_start,
    output logic              eng_read,
    output logic [63:0]       eng_buf_addr,
    output logic [31:0]       eng_count,
    output logic [31:0]       eng_lba,
    input  logic              eng_done,
    input  logic              eng_fail,
    output logic              irq
);
    localparam int DATA_W = 32;

    bd_sel_e     sel;
    logic        dec_err;
    bd_state_e   state;
    logic        idle;
    logic        acc_ok;
    logic        wr_ok;
    logic        go;
    logic        go_read;
    logic        ack_rd;
    logic [31:0] irq_en;
    logic [31:0] rd_mux;

    blkdev_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (bus_addr),
        .write (bus_write),
        .sel   (sel),
        .err   (dec_err)
    );

    assign idle    = (state == ST_IDLE);
    assign acc_ok  = bus_valid && !dec_err;
    assign wr_ok   = acc_ok && bus_write;
    assign go_read = (bus_wdata == OPC_READ);
    assign go      = wr_ok && (sel == SEL_OP) && idle &&
                     ((bus_wdata == OPC_READ) || (bus_wdata == OPC_WRITE));
    assign ack_rd  = acc_ok && !bus_write && (sel == SEL_STATUS);

    blkdev_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .sel      (sel),
        .wdata    (bus_wdata),
        .idle     (idle),
        .buf_addr (eng_buf_addr),
        .count    (eng_count),
        .lba      (eng_lba),
        .irq_en   (irq_en)
    );

    blkdev_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_read  (go_read),
        .ack_rd   (ack_rd),
        .done     (eng_done),
        .fail     (eng_fail),
        .state    (state),
        .start    (eng_start),
        .dir_read (eng_read)
    );

    // Read data selection for legal reads
    always_comb begin
        case (sel)
            SEL_BUF_LO:    rd_mux = eng_buf_addr[31:0];
            SEL_BUF_HI:    rd_mux = eng_buf_addr[63:32];
            SEL_COUNT:     rd_mux = eng_count;
            SEL_LBA:       rd_mux = eng_lba;
            SEL_STATUS:    rd_mux = {29'd0, state};
            SEL_IRQ_EN:    rd_mux = irq_en;
            SEL_SIZE:      rd_mux = DEV_BLOCKS;
            SEL_BLK_BYTES: rd_mux = BLOCK_BYTES;
            default:       rd_mux = '0;
        endcase
    end

    // Registered bus response, one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid;
            rsp_err   <= bus_valid && dec_err;
            rsp_rdata <= (acc_ok && !bus_write) ? rd_mux : '0;
        end
    end

    // Level interrupt gated by the enable register
    assign irq = (irq_en != '0) && is_terminal(state);

    // R4
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid));

    // R3
    err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && dec_err) |=> !eng_start);

    // R10
    irq_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !eng_start);

endmodule

// File: tb/blkdev_ctrl_regs_bench.sv
// Bench: a behavioural reference model is advanced on each rising edge and
// compared with the design's outputs on every falling edge.
module blkdev_ctrl_regs_bench;
    localparam int          ADDR_W = 6;
    localparam logic [31:0] DEVB   = 32'h0004_0000;
    localparam logic [31:0] BLKB   = 32'd512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic rsp_valid, rsp_err, eng_start, eng_read, irq;
    logic [31:0] rsp_rdata, eng_count, eng_lba;
    logic [63:0] eng_buf_addr;
    logic eng_done = 1'b0, eng_fail = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    blkdev_ctrl_regs #(.ADDR_W(ADDR_W), .DEV_BLOCKS(DEVB), .BLOCK_BYTES(BLKB)) u_blkdev_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .eng_start(eng_start),
        .eng_read(eng_read), .eng_buf_addr(eng_buf_addr), .eng_count(eng_count),
        .eng_lba(eng_lba), .eng_done(eng_done), .eng_fail(eng_fail), .irq(irq));

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // reference model state
    int m_st = 0, m_dir = 0;
    logic [63:0] m_buf = 0;
    logic [31:0] m_cnt = 0, m_lba = 0, m_ien = 1, m_rd = 0;
    bit m_rv = 0, m_err = 0, m_start = 0;
    string m_tag = "R1";

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        int old, idx;
        if (!rst_n) begin
            m_st = 0; m_dir = 0; m_buf = 0; m_cnt = 0; m_lba = 0; m_ien = 1;
            m_rv = 0; m_err = 0; m_rd = 0; m_start = 0;
        end else begin
            old = m_st; m_rv = 0; m_start = 0;
            if (eng_done && old == 1)
                m_st = m_dir ? (eng_fail ? 4 : 2) : (eng_fail ? 5 : 3);
            if (bus_valid) begin
                m_rv = 1; m_err = 0; m_rd = 0; m_tag = cur_tag;
                idx = int'(bus_addr) / 4;
                if ((bus_addr % 4) != 0 || idx > 8) m_err = 1;
                else if (bus_write) begin
                    case (idx)
                        0: if (old == 0) m_buf[31:0] = bus_wdata;
                        1: if (old == 0) m_cnt = bus_wdata;
                        2: if (old == 0) m_lba = bus_wdata;
                        3: if (old == 0 && (bus_wdata == 1 || bus_wdata == 2)) begin
                               m_start = 1; m_st = 1; m_dir = (bus_wdata == 1) ? 1 : 0;
                           end
                        5: m_ien = bus_wdata;
                        8: if (old == 0) m_buf[63:32] = bus_wdata;
                        default: m_err = 1;
                    endcase
                end else begin
                    case (idx)
                        0: m_rd = m_buf[31:0];
                        1: m_rd = m_cnt;
                        2: m_rd = m_lba;
                        4: begin m_rd = old; if (old >= 2) m_st = 0; end
                        5: m_rd = m_ien;
                        6: m_rd = DEVB;
                        7: m_rd = BLKB;
                        8: m_rd = m_buf[63:32];
                        default: m_err = 1;
                    endcase
                end
            end
        end
    end

    // Comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4", "rsp_valid", rsp_valid, m_rv);
            if (m_rv) begin
                chk(m_err ? "R3" : m_tag, "rsp_err", rsp_err, m_err);
                chk(m_tag, "rsp_rdata", rsp_rdata, m_rd);
            end
            chk("R5", "eng_start", eng_start, m_start);
            if (m_start) begin
                chk("R5", "eng_read", eng_read, m_dir);
                chk("R5", "eng_buf_addr", eng_buf_addr, m_buf);
                chk("R5", "eng_count", eng_count, m_cnt);
                chk("R5", "eng_lba", eng_lba, m_lba);
            end
            chk("R10", "irq", irq, (m_ien != 0 && m_st >= 2));
        end
    end

    task automatic acc(bit wr, int addr, logic [31:0] d, string tag);
        @(negedge clk);
        cur_tag = tag; bus_valid = 1; bus_write = wr;
        bus_addr = ADDR_W'(addr); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic finish_done(bit f);
        @(negedge clk);
        eng_done = 1; eng_fail = f;
        @(negedge clk);
        eng_done = 0; eng_fail = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "irq", irq, 0);
        chk("R1", "eng_start", eng_start, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        for (int a = 0; a <= 8; a++) acc(0, a * 4, 0, "R1");
        // R2 readback and fixed values
        acc(1, 'h00, 32'h1000_0040, "R2");
        acc(1, 'h20, 32'h0000_0012, "R2");
        acc(1, 'h04, 32'd3, "R2");
        acc(1, 'h08, 32'h77, "R2");
        acc(1, 'h14, 32'd0, "R2");
        for (int a = 0; a <= 8; a++) if (a != 3) acc(0, a * 4, 0, "R2");
        acc(1, 'h14, 32'd1, "R2");
        // R3 illegal accesses
        acc(0, 'h24, 0, "R3");
        acc(0, 'h3C, 0, "R3");
        acc(0, 'h01, 0, "R3");
        acc(1, 'h06, 32'hFF, "R3");
        acc(1, 'h10, 32'd2, "R3");
        acc(1, 'h18, 32'd5, "R3");
        acc(1, 'h1C, 32'd5, "R3");
        acc(0, 'h0C, 0, "R3");
        acc(0, 'h04, 0, "R3");
        acc(0, 'h10, 0, "R3");
        // R6 non-launching codes
        acc(1, 'h0C, 32'd0, "R6");
        acc(1, 'h0C, 32'd3, "R6");
        acc(1, 'h0C, 32'hFFFF_FFFF, "R6");
        acc(0, 'h10, 0, "R6");
        // R5 launch a read transfer
        acc(1, 'h0C, 32'd1, "R5");
        // R7 writes while busy are dropped
        acc(1, 'h04, 32'd9, "R7");
        acc(1, 'h08, 32'd5, "R7");
        acc(1, 'h00, 32'h0, "R7");
        acc(1, 'h20, 32'hABCD, "R7");
        acc(1, 'h0C, 32'd2, "R7");
        for (int a = 0; a <= 8; a++) if (a != 3 && a != 4) acc(0, a * 4, 0, "R7");
        acc(0, 'h10, 0, "R9");
        // R8 completion, R10 gating, R9 acknowledge
        finish_done(0);
        repeat (2) @(negedge clk);
        acc(1, 'h14, 32'd0, "R10");
        acc(1, 'h14, 32'd4, "R10");
        acc(0, 'h10, 0, "R9");
        acc(0, 'h10, 0, "R9");
        // R8 stray completion in idle is ignored
        finish_done(1);
        acc(0, 'h10, 0, "R8");
        // R8 write direction failing
        acc(1, 'h04, 32'd7, "R5");
        acc(1, 'h0C, 32'd2, "R5");
        finish_done(1);
        acc(0, 'h10, 0, "R8");
        // R8 read direction failing
        acc(1, 'h0C, 32'd1, "R5");
        finish_done(1);
        acc(0, 'h10, 0, "R8");
        // R8 write direction ok, with interrupts disabled
        acc(1, 'h14, 32'd0, "R10");
        acc(1, 'h0C, 32'd2, "R5");
        finish_done(0);
        repeat (2) @(negedge clk);
        acc(0, 'h10, 0, "R8");
        acc(0, 'h10, 0, "R9");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule